// File: doc/BRIEF.md
# Serial Flash Continuous Read Responder

This block is the device side of a serial data-flash part, limited to continuous array reads. A host talks to it over a four-wire SPI link in mode 0: chip select active low, SI captured on rising SCK, SO changed on falling SCK, most significant bit first. The responder samples SCK, SI and chip select with its own system clock through a synchronizer. It decodes the command byte and gathers a 24-bit address. For the fast read it skips one dummy byte. It then streams array bytes on SO for as long as the host keeps clocking, moving to the next byte after each one.

Two page layouts are supported and chosen by an input that is captured when chip select falls. In the 528-byte layout the address carries a 12-bit page number above a 10-bit byte offset. In the 512-byte layout the address is a plain linear byte address. Reads pass page ends and the end of the array without any pause. The array holds a fixed computed pattern, and its page count is a parameter so that simulation can use a small array.

The controller has six named states. ST_IDLE waits for chip select to fall. ST_OPCODE collects the command byte and leaves for ST_ADDR on a known read code or for ST_IGNORE on anything else. ST_ADDR collects 24 address bits and moves to ST_DUMMY for the fast read or to ST_DATA otherwise. ST_DUMMY absorbs 8 bits and moves to ST_DATA. ST_DATA streams bytes. ST_IGNORE holds SO released. From every state a high chip select returns the controller to ST_IDLE.

Top module: `sfr_read_responder`

## Requirements
- R1: After reset, spi_so_en is 0.
- R2: Command codes 8'h03 and 8'h01 take three address bytes and no dummy byte. The first data bit appears at the falling SCK edge after the 24th address bit, and bytes are sent MSB first.
- R3: Command code 8'h0B takes three address bytes and then one dummy byte. SO stays released during the dummy byte, and data begins at the falling edge after its 8th bit.
- R4: In 528-byte mode (mode_512 = 0), address bits [21:10] give the page, taken modulo PAGES, and bits [9:0] give the starting byte. The byte at array index i = page*528 + byte has the value (i mod 256) XOR ((5*(i div 256)) mod 256).
- R5: In 512-byte mode (mode_512 = 1), address bits [20:0] form a linear byte address. The page is bits [20:9] modulo PAGES, the byte is bits [8:0], the index is page*512 + byte, and the value follows the pattern in R4.
- R6: After the last byte of a page, the next byte comes from byte 0 of the following page with no extra SCK cycles.
- R7: After the last byte of page PAGES-1, the next byte comes from byte 0 of page 0 with no extra SCK cycles.
- R8: In 528-byte mode, a starting byte of 528 or more starts the read at byte 0 of the next page, wrapping past the last page to page 0.
- R9: A high chip select ends the transaction at any point, including mid-byte. spi_so_en is 0 within 5 system clocks, and the next transaction starts cleanly.
- R10: An unknown command code keeps spi_so_en at 0 until chip select rises, whatever SCK and SI do.
- R11: mode_512 is captured when chip select falls. Changes later in the same transaction have no effect.
- R12: spi_so_en is 0 while the command, address and dummy bytes are being received, and 1 for every data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the SPI lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_512 | input | 1 | 1 selects linear 512-byte pages, 0 selects 528-byte split addressing |
| spi_sck | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_si | input | 1 | Serial data from the host |
| spi_so | output | 1 | Serial data to the host |
| spi_so_en | output | 1 | Drive enable for SO; 0 means the pad is high impedance |

## Verification
A wrong bit counter or a wrong state transition shows up as a shifted data stream. The first data byte then comes out misaligned by whole bits, or the output enable rises during an address or dummy byte, and both are seen within the first data byte. A wrong page or byte register is hidden until the stream reaches a boundary. Starting reads a few bytes before a page end, before the array end, and at a clamped offset exposes such a fault in the second to fourth byte.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_IGNORE
    } sfr_state_e;

    localparam logic [7:0] CMD_RD_FAST = 8'h0B;
    localparam logic [7:0] CMD_RD_STD  = 8'h03;
    localparam logic [7:0] CMD_RD_LOWP = 8'h01;

    localparam int SPLIT_PAGE = 528;
    localparam int BIN_PAGE   = 512;
    localparam int ADDR_BITS  = 24;
    localparam int BYTE_BITS  = 8;
    localparam int OFS_W      = 10;
    localparam int PATTERN_MUL = 5;

endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/sfr_addr_gen.sv
module sfr_addr_gen
    import sfr_pkg::*;
#(
    parameter int PAGES = 8,
    parameter int PG_W  = (PAGES > 1) ? $clog2(PAGES) : 1,
    parameter int IDX_W = $clog2(PAGES * SPLIT_PAGE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_bin,
    input  logic             load,
    input  logic [21:0]      start_addr,
    input  logic             advance,
    output logic [IDX_W-1:0] idx
);

    logic [PG_W-1:0]  page_q;
    logic [OFS_W-1:0] ofs_q;
    logic [11:0]      raw_pg;
    logic [OFS_W-1:0] raw_ofs;
    logic [PG_W-1:0]  pg_mod;
    logic [PG_W-1:0]  load_pg;
    logic [OFS_W-1:0] load_ofs;
    logic [OFS_W-1:0] last_ofs;
    int               page_len;

    function automatic logic [PG_W-1:0] next_page(input logic [PG_W-1:0] p);
        return (p == PG_W'(PAGES - 1)) ? '0 : PG_W'(p + 1'b1);
    endfunction

    // split the start address according to the latched layout
    always_comb begin
        if (mode_bin) begin
            raw_pg  = {1'b0, start_addr[20:9]};
            raw_ofs = {1'b0, start_addr[8:0]};
        end else begin
            raw_pg  = start_addr[21:10];
            raw_ofs = start_addr[9:0];
        end
        pg_mod = PG_W'(32'(raw_pg) % PAGES);
        if (!mode_bin && (raw_ofs >= OFS_W'(SPLIT_PAGE))) begin
            load_pg  = next_page(pg_mod);
            load_ofs = '0;
        end else begin
            load_pg  = pg_mod;
            load_ofs = raw_ofs;
        end
    end

    assign page_len = mode_bin ? BIN_PAGE : SPLIT_PAGE;
    assign last_ofs = OFS_W'(page_len - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            ofs_q  <= '0;
        end else if (load) begin
            page_q <= load_pg;
            ofs_q  <= load_ofs;
        end else if (advance) begin
            if (ofs_q == last_ofs) begin
                ofs_q  <= '0;
                page_q <= next_page(page_q);
            end else begin
                ofs_q <= ofs_q + 1'b1;
            end
        end
    end

    assign idx = IDX_W'(32'(page_q) * page_len + 32'(ofs_q));

    // clamped starting offset lands on byte 0
    assert_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !mode_bin && (start_addr[9:0] >= OFS_W'(SPLIT_PAGE))) |=> (ofs_q == '0));

    // page end rolls to byte 0
    assert_page_roll_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && (ofs_q == last_ofs)) |=> (ofs_q == '0));

    // array end rolls to page 0
    assert_array_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && (ofs_q == last_ofs) && (page_q == PG_W'(PAGES - 1))) |=> (page_q == '0));

endmodule

// File: rtl/sfr_pattern_rom.sv
module sfr_pattern_rom
    import sfr_pkg::*;
#(
    parameter int IDX_W = 13
) (
    input  logic [IDX_W-1:0]     idx,
    output logic [BYTE_BITS-1:0] data
);

    logic [BYTE_BITS-1:0] lo_part;
    logic [BYTE_BITS-1:0] hi_part;

    always_comb begin
        lo_part = BYTE_BITS'(idx);
        hi_part = BYTE_BITS'((32'(idx) >> 8) * PATTERN_MUL);
        data    = lo_part ^ hi_part;
    end

endmodule

// File: rtl/sfr_read_responder.sv
module sfr_read_responder
    import sfr_pkg::*;
#(
    parameter int PAGES       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_512,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_si,
    output logic spi_so,
    output logic spi_so_en
);

    localparam int IDX_W = $clog2(PAGES * SPLIT_PAGE);
    localparam int CNT_W = $clog2(ADDR_BITS);

    sfr_state_e state_q, state_d;

    logic [2:0]           sync_q;
    logic                 sck_s, cs_s, si_s;
    logic                 sck_prev;
    logic                 sck_rise, sck_fall;
    logic [CNT_W-1:0]     bit_cnt;
    logic [22:0]          shreg;
    logic [7:0]           op_byte;
    logic                 dummy_q;
    logic                 mode_q;
    logic                 addr_load;
    logic                 addr_adv;
    logic [IDX_W-1:0]     rd_idx;
    logic [BYTE_BITS-1:0] rd_byte;
    logic [BYTE_BITS-1:0] out_sh;
    logic [2:0]           out_cnt;
    logic                 so_q, so_en_q;

    sfr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({spi_sck, spi_cs_n, spi_si}),
        .q    (sync_q)
    );

    assign sck_s = sync_q[2];
    assign cs_s  = sync_q[1];
    assign si_s  = sync_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_s;
    end

    assign sck_rise = sck_s & ~sck_prev;
    assign sck_fall = ~sck_s & sck_prev;
    assign op_byte  = {shreg[6:0], si_s};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cs_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_OPCODE;
                ST_OPCODE: begin
                    if (sck_rise && bit_cnt == CNT_W'(7)) begin
                        if (op_byte == CMD_RD_FAST || op_byte == CMD_RD_STD ||
                            op_byte == CMD_RD_LOWP)
                            state_d = ST_ADDR;
                        else
                            state_d = ST_IGNORE;
                    end
                end
                ST_ADDR: begin
                    if (sck_rise && bit_cnt == CNT_W'(ADDR_BITS - 1))
                        state_d = dummy_q ? ST_DUMMY : ST_DATA;
                end
                ST_DUMMY: begin
                    if (sck_rise && bit_cnt == CNT_W'(7)) state_d = ST_DATA;
                end
                ST_DATA:   state_d = ST_DATA;
                ST_IGNORE: state_d = ST_IGNORE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // command-side datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            dummy_q <= 1'b0;
            mode_q  <= 1'b0;
        end else begin
            if (state_d != state_q)  bit_cnt <= '0;
            else if (sck_rise)       bit_cnt <= bit_cnt + 1'b1;
            if (sck_rise)            shreg <= {shreg[21:0], si_s};
            if (state_q == ST_OPCODE && sck_rise && bit_cnt == CNT_W'(7))
                dummy_q <= (op_byte == CMD_RD_FAST);
            if (state_q == ST_IDLE && !cs_s)
                mode_q <= mode_512;
        end
    end

    assign addr_load = (state_q == ST_ADDR) && sck_rise && (bit_cnt == CNT_W'(ADDR_BITS - 1));
    assign addr_adv  = (state_q == ST_DATA) && sck_fall && (out_cnt == 3'd0);

    sfr_addr_gen #(.PAGES(PAGES), .IDX_W(IDX_W)) i_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_bin  (mode_q),
        .load      (addr_load),
        .start_addr({shreg[20:0], si_s}),
        .advance   (addr_adv),
        .idx       (rd_idx)
    );

    sfr_pattern_rom #(.IDX_W(IDX_W)) i_rom (
        .idx (rd_idx),
        .data(rd_byte)
    );

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            so_q    <= 1'b0;
            so_en_q <= 1'b0;
            out_sh  <= '0;
            out_cnt <= '0;
        end else if (state_q != ST_DATA) begin
            so_en_q <= 1'b0;
            out_cnt <= '0;
        end else if (sck_fall) begin
            so_en_q <= 1'b1;
            if (out_cnt == 3'd0) begin
                so_q   <= rd_byte[7];
                out_sh <= {rd_byte[6:0], 1'b0};
            end else begin
                so_q   <= out_sh[7];
                out_sh <= {out_sh[6:0], 1'b0};
            end
            out_cnt <= out_cnt + 1'b1;
        end
    end

    assign spi_so    = so_q;
    assign spi_so_en = so_en_q;

    assert_cs_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> ##1 !spi_so_en);

    assert_ignore_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |=> !spi_so_en);

    assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(mode_q));

    assert_no_early_drive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPCODE || state_q == ST_ADDR || state_q == ST_DUMMY) |=> !spi_so_en);

endmodule

// File: tb/test_sfr_read_responder.sv
module test_sfr_read_responder;

    localparam int PAGES = 8;
    localparam int HALF  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_512 = 1'b0;
    logic spi_sck = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_si = 1'b0;
    logic spi_so;
    logic spi_so_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sfr_read_responder #(.PAGES(PAGES)) i_sfr_read_responder (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_512 (mode_512),
        .spi_sck  (spi_sck),
        .spi_cs_n (spi_cs_n),
        .spi_si   (spi_si),
        .spi_so   (spi_so),
        .spi_so_en(spi_so_en)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'(i) ^ 8'((i >> 8) * 5);
    endfunction

    function automatic int exp_idx(input logic [23:0] a, input bit m512, input int k);
        int pb = m512 ? 512 : 528;
        int pg = m512 ? int'(a[20:9]) : int'(a[21:10]);
        int by = m512 ? int'(a[8:0])  : int'(a[9:0]);
        pg = pg % PAGES;
        if (by >= pb) begin by = 0; pg = (pg + 1) % PAGES; end
        for (int s = 0; s < k; s++) begin
            by++;
            if (by == pb) begin by = 0; pg = (pg + 1) % PAGES; end
        end
        return pg * pb + by;
    endfunction

    function automatic logic [23:0] a528(input int pg, input int by);
        return {2'b00, 12'(pg), 10'(by)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx,
                        output logic en_all, output logic en_any);
        rx = '0; en_all = 1'b1; en_any = 1'b0;
        for (int b = 7; b > 7 - nbits; b--) begin
            spi_si = tx[b];
            wait_clk(HALF);
            rx[b]  = spi_so;
            en_all = en_all & spi_so_en;
            en_any = en_any | spi_so_en;
            spi_sck = 1'b1;
            wait_clk(HALF);
            spi_sck = 1'b0;
        end
    endtask

    task automatic run_read(input logic [7:0] op, input logic [23:0] addr, input bit m512,
                            input int nbytes, input bit flip_mode, input string req);
        logic [7:0] rx;
        logic ea, en;
        mode_512 = m512;
        spi_cs_n = 1'b0;
        wait_clk(HALF);
        if (flip_mode) mode_512 = ~m512;
        xfer(op, 8, rx, ea, en);
        check(!en, {req, " R12 cmd"}, en, 0);
        for (int k = 2; k >= 0; k--) begin
            xfer(addr[k*8 +: 8], 8, rx, ea, en);
            check(!en, {req, " R12 addr"}, en, 0);
        end
        if (op == 8'h0B) begin
            xfer(8'hFF, 8, rx, ea, en);
            check(!en, {req, " R3 dummy"}, en, 0);
        end
        for (int k = 0; k < nbytes; k++) begin
            xfer(8'h00, 8, rx, ea, en);
            check(rx == pat(exp_idx(addr, m512, k)), req, rx, pat(exp_idx(addr, m512, k)));
            check(ea, {req, " R12 data en"}, ea, 1);
        end
        spi_cs_n = 1'b1;
        wait_clk(HALF);
        check(!spi_so_en, {req, " R9 release"}, spi_so_en, 0);
        wait_clk(HALF);
    endtask

    initial begin
        logic [7:0] rx;
        logic ea, en;
        void'($urandom(32'd7719));
        wait_clk(3);
        check(!spi_so_en, "R1 reset", spi_so_en, 0);
        rst_n = 1'b1;
        wait_clk(4);
        check(!spi_so_en, "R1 after reset", spi_so_en, 0);

        run_read(8'h03, a528(2, 5), 1'b0, 4, 1'b0, "R2 R4 std 528");
        run_read(8'h01, 24'd1234, 1'b1, 4, 1'b0, "R2 R5 lowp 512");
        run_read(8'h0B, a528(5, 300), 1'b0, 3, 1'b0, "R3 fast 528");
        run_read(8'h0B, 24'd3000, 1'b1, 3, 1'b0, "R3 fast 512");
        run_read(8'h03, a528(1, 526), 1'b0, 4, 1'b0, "R6 cross 528");
        run_read(8'h03, 24'(512*3-2), 1'b1, 4, 1'b0, "R6 cross 512");
        run_read(8'h01, a528(PAGES-1, 526), 1'b0, 4, 1'b0, "R7 wrap 528");
        run_read(8'h0B, 24'(512*PAGES-1), 1'b1, 3, 1'b0, "R7 wrap 512");
        run_read(8'h03, a528(3, 600), 1'b0, 2, 1'b0, "R8 clamp");
        run_read(8'h03, a528(PAGES-1, 1000), 1'b0, 2, 1'b0, "R8 clamp wrap");
        run_read(8'h03, a528(PAGES+1, 7), 1'b0, 2, 1'b0, "R4 page modulo");
        run_read(8'h03, a528(4, 20), 1'b0, 3, 1'b1, "R11 mode 528 held");
        run_read(8'h03, 24'd2100, 1'b1, 3, 1'b1, "R11 mode 512 held");

        // R10: unknown command code
        spi_cs_n = 1'b0;
        wait_clk(HALF);
        xfer(8'hA5, 8, rx, ea, en);
        for (int k = 0; k < 7; k++) begin
            xfer(8'(k * 37 + 3), 8, rx, ea, en);
            check(!en, "R10 unknown cmd", en, 0);
        end
        spi_cs_n = 1'b1;
        wait_clk(2 * HALF);

        // R9: abort mid-byte, then a clean read
        spi_cs_n = 1'b0;
        wait_clk(HALF);
        xfer(8'h03, 8, rx, ea, en);
        xfer(8'h00, 8, rx, ea, en);
        xfer(8'h04, 8, rx, ea, en);
        xfer(8'h10, 8, rx, ea, en);
        xfer(8'h00, 8, rx, ea, en);
        xfer(8'h00, 3, rx, ea, en);
        spi_cs_n = 1'b1;
        wait_clk(5);
        check(!spi_so_en, "R9 abort mid-byte", spi_so_en, 1'b0);
        wait_clk(2 * HALF);
        run_read(8'h03, a528(6, 9), 1'b0, 2, 1'b0, "R9 restart");

        for (int t = 0; t < 24; t++) begin
            bit m = 1'(($urandom % 2));
            int sel = $urandom % 3;
            logic [7:0] op = (sel == 0) ? 8'h0B : ((sel == 1) ? 8'h03 : 8'h01);
            int pg = $urandom % (PAGES + 3);
            int by = m ? int'($urandom % 512) : int'($urandom % 1024);
            logic [23:0] ad = m ? 24'(pg * 512 + by) : a528(pg, by);
            run_read(op, ad, m, 1 + int'($urandom % 5), 1'b0, m ? "R5 random" : "R4 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule